// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a raw pulse-width signal, usually produced by comparing a centre-aligned up/down counter against a duty value, into a pair of gate-drive signals, A and B. In complementary mode, B is built from the inverse of the raw signal. Each output holds off its rising edge for its own programmable number of whole clock cycles. Falling edges pass through at once. Because of this, the switch that is turning off always drops before its partner turns on, and the two outputs are never high together.

With complementary mode off, the block becomes two independent rising-edge delay lines. A follows the raw A input and B follows the raw B input, and each still uses its own dead-time value. If a source goes low before its dead-time count runs out, the pending rising edge is cancelled. The next rising edge then starts a fresh count. Both outputs are registered and feed the downstream output-control stage.

Top module: `pwm_deadtime_pair`

## Requirements
- R1: While `rst` is high, and after it is released until a source is seen high, both `out_a` and `out_b` are low.
- R2: A source that is sampled low at a clock edge drives its output low at that same edge, with no dead time, whatever the delay setting.
- R3: With a dead-time value of 0, a source sampled high after being low drives its output high at that same edge.
- R4: With a dead-time value of N (1 to 2^DT_W-1), the output rises at the edge N cycles after the edge that first samples the source high, provided the source stays high throughout.
- R5: If a source goes low while its rising edge is still being delayed, that edge is dropped and the output stays low. A later rise starts a full new count.
- R6: When `comp_en` is 1, channel A's source is `raw_a`, channel B's source is the inverse of `raw_a`, and `raw_b` has no effect.
- R7: `dt_a` sets only channel A's delay and `dt_b` sets only channel B's delay.
- R8: When `comp_en` has been 1 at the previous edge, `out_a` and `out_b` are never both high.
- R9: When `comp_en` is 0, channel B's source is `raw_b`, delayed by `dt_b`.
- R10: Dead-time values are DT_W = 11 bits wide, so the largest setting, 2047, delays a rise by 2047 cycles.
- R11: The dead-time value is captured at the edge that first samples the source high. Changing it while a count is pending does not alter that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_en | input | 1 | 1: complementary pair from `raw_a`; 0: independent channels |
| raw_a | input | 1 | Raw PWM for channel A (and B in complementary mode) |
| raw_b | input | 1 | Raw PWM for channel B in independent mode |
| dt_a | input | DT_W | Channel A rising-edge delay in clock cycles |
| dt_b | input | DT_W | Channel B rising-edge delay in clock cycles |
| out_a | output | 1 | Registered output A |
| out_b | output | 1 | Registered output B |

## Verification
Every output is one register away from its inputs. A falling edge, or a rise with zero delay, therefore appears at the first clock edge that samples the new input level. A rise with a delay of N appears N edges after that. The bench drives inputs on the falling clock edge. It advances its model once per rising edge and compares both outputs at the following falling edge, so each expectation is checked in exactly the cycle it becomes due. The model counts how many consecutive edges each source has been sampled high and compares that count with the delay captured on the first of those edges.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int CH_NUM = 2;

  typedef enum logic [1:0] {
    DLY_LOW  = 2'd0,
    DLY_WAIT = 2'd1,
    DLY_HIGH = 2'd2
  } dly_state_e;
endpackage

// File: rtl/pwm_dt_src_sel.sv
module pwm_dt_src_sel (
  input  logic comp_en,
  input  logic raw_a,
  input  logic raw_b,
  output logic src_a,
  output logic src_b
);
  // Channel B follows the inverse of A in complementary mode (R6), else raw_b (R9)
  always_comb begin
    src_a = raw_a;
    src_b = comp_en ? ~raw_a : raw_b;
  end
endmodule

// File: rtl/pwm_dt_edge_delay.sv
module pwm_dt_edge_delay
  import pwm_dt_pkg::*;
#(
  parameter int DT_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src,
  input  logic [DT_W-1:0] dt,
  output logic            q
);
  logic            prev;
  logic [DT_W-1:0] cnt;
  dly_state_e      st;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      cnt  <= '0;
      st   <= DLY_LOW;
      q    <= 1'b0;
    end else begin
      prev <= src;
      if (!src) begin
        // falling edge or low level: immediate, cancels any pending rise
        st  <= DLY_LOW;
        cnt <= '0;
        q   <= 1'b0;
      end else if (!prev) begin
        // rising edge: capture the delay now
        if (dt == '0) begin
          st <= DLY_HIGH;
          q  <= 1'b1;
        end else begin
          st  <= DLY_WAIT;
          cnt <= dt;
          q   <= 1'b0;
        end
      end else if (st == DLY_WAIT) begin
        if (cnt == DT_W'(1)) begin
          st  <= DLY_HIGH;
          cnt <= '0;
          q   <= 1'b1;
        end else begin
          cnt <= cnt - DT_W'(1);
        end
      end
    end
  end

  // R2: a low source forces the output low at the next edge
  p_fall_immediate_r2: assert property (@(posedge clk) disable iff (rst)
    !src |=> !q);

  // R3: zero delay passes the rise straight through
  p_zero_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (src && !prev && dt == '0) |=> q);

  // R4: a nonzero delay holds the output low after the rise
  p_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
    (src && !prev && dt != '0) |=> !q);

  // R10: a pending count never sits at zero
  p_count_live_r10: assert property (@(posedge clk) disable iff (rst)
    (st == DLY_WAIT) |-> (cnt != '0));

  // R5: while waiting, the output stays low
  p_wait_low_r5: assert property (@(posedge clk) disable iff (rst)
    (st == DLY_WAIT) |-> !q);
endmodule

// File: rtl/pwm_deadtime_pair.sv
module pwm_deadtime_pair
  import pwm_dt_pkg::*;
#(
  parameter int DT_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            comp_en,
  input  logic            raw_a,
  input  logic            raw_b,
  input  logic [DT_W-1:0] dt_a,
  input  logic [DT_W-1:0] dt_b,
  output logic            out_a,
  output logic            out_b
);
  logic [CH_NUM-1:0]           src;
  logic [CH_NUM-1:0][DT_W-1:0] dtv;
  logic [CH_NUM-1:0]           qv;

  pwm_dt_src_sel u_sel (
    .comp_en (comp_en),
    .raw_a   (raw_a),
    .raw_b   (raw_b),
    .src_a   (src[0]),
    .src_b   (src[1])
  );

  assign dtv[0] = dt_a;  // R7
  assign dtv[1] = dt_b;

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    pwm_dt_edge_delay #(.DT_W(DT_W)) u_dly (
      .clk (clk),
      .rst (rst),
      .src (src[g]),
      .dt  (dtv[g]),
      .q   (qv[g])
    );
  end

  assign out_a = qv[0];
  assign out_b = qv[1];

  // R8: complementary pair never overlaps
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    $past(comp_en) |-> !(out_a && out_b));

  // R6: in complementary mode a high raw_a keeps B low
  p_comp_inverse_r6: assert property (@(posedge clk) disable iff (rst)
    (comp_en && raw_a) |=> !out_b);

  // R9: in independent mode a low raw_b keeps B low
  p_indep_b_r9: assert property (@(posedge clk) disable iff (rst)
    (!comp_en && !raw_b) |=> !out_b);

  // R1: outputs low right after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b));
endmodule

// File: tb/pwm_deadtime_pair_tb.sv
`timescale 1ns/1ps
module pwm_deadtime_pair_tb;
  localparam int DT_W = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            comp_en = 1'b1;
  logic            raw_a = 1'b0;
  logic            raw_b = 1'b0;
  logic [DT_W-1:0] dt_a = '0;
  logic [DT_W-1:0] dt_b = '0;
  logic            out_a, out_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int run_a = 0, run_b = 0, d_a = 0, d_b = 0;
  logic exp_a = 1'b0, exp_b = 1'b0;
  logic comp_seen = 1'b0;

  always #2.5 clk = ~clk;

  pwm_deadtime_pair #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst(rst), .comp_en(comp_en), .raw_a(raw_a), .raw_b(raw_b),
    .dt_a(dt_a), .dt_b(dt_b), .out_a(out_a), .out_b(out_b)
  );

  // expected output: high once the run of high samples exceeds the delay
  function automatic logic model_q(input int run, input int d);
    return (run > d);
  endfunction

  function automatic int next_run(input logic r, input logic s, input int run);
    if (r || !s) return 0;
    return run + 1;
  endfunction

  task automatic check(input string tag, input logic act, input logic expv, input string nm);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, expv, $time);
    end
  endtask

  // one clock: advance model with inputs present now, then compare at negedge
  task automatic cyc(input string tag);
    logic sa, sb;
    sa = raw_a;
    sb = comp_en ? ~raw_a : raw_b;
    run_a = next_run(rst, sa, run_a);
    run_b = next_run(rst, sb, run_b);
    if (run_a == 1) d_a = int'(dt_a);
    if (run_b == 1) d_b = int'(dt_b);
    exp_a = model_q(run_a, d_a);
    exp_b = model_q(run_b, d_b);
    comp_seen = comp_en && !rst;
    @(posedge clk);
    @(negedge clk);
    check(tag, out_a, exp_a, "out_a");
    check(tag, out_b, exp_b, "out_b");
    if (comp_seen) check("R8", out_a && out_b, 1'b0, "overlap");
  endtask

  task automatic cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    // R1: reset holds both low even with raw_a high
    raw_a = 1'b1;
    cycles(4, "R1");
    rst = 1'b0;
    raw_a = 1'b0;
    cycles(3, "R1");

    // R3 / R2 / R6: zero delay, complementary mode, raw_b toggled but ignored
    dt_a = '0; dt_b = '0;
    for (int i = 0; i < 6; i++) begin
      raw_a = ~raw_a;
      raw_b = $urandom_range(0, 1);
      cycles(3, "R3");
    end

    // R4 / R7: distinct delays 3 and 5, square wave
    dt_a = 11'd3; dt_b = 11'd5;
    for (int i = 0; i < 6; i++) begin
      raw_a = ~raw_a;
      cycles(10, "R4");
    end

    // R5: short high pulse shorter than the delay is dropped
    raw_a = 1'b0; cycles(8, "R5");
    dt_a = 11'd6;
    raw_a = 1'b1; cycles(2, "R5");
    raw_a = 1'b0; cycles(2, "R5");
    raw_a = 1'b1; cycles(9, "R5");

    // R11: delay change during a pending count
    raw_a = 1'b0; dt_a = 11'd4; cycles(8, "R11");
    raw_a = 1'b1; cyc("R11");
    dt_a = '0; cycles(7, "R11");

    // R9: independent mode, raw_b with its own delay
    comp_en = 1'b0; dt_a = 11'd2; dt_b = 11'd1;
    for (int i = 0; i < 40; i++) begin
      raw_a = $urandom_range(0, 1);
      if ((i % 4) == 0) raw_b = ~raw_b;
      cyc("R9");
    end

    // R10: largest delay
    comp_en = 1'b1; raw_a = 1'b0; dt_a = 11'd2047; dt_b = 11'd0;
    cycles(4, "R10");
    raw_a = 1'b1;
    cycles(2050, "R10");
    raw_a = 1'b0;
    cycles(4, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ((i % 500) == 0) begin
        comp_en = $urandom_range(0, 1);
        dt_a = DT_W'($urandom_range(0, 7));
        dt_b = DT_W'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 5) == 0) raw_a = ~raw_a;
      if ($urandom_range(0, 5) == 0) raw_b = ~raw_b;
      cyc(comp_en ? "R6" : "R9");
    end

    // R1: reset mid-run clears outputs
    raw_a = 1'b1; dt_a = '0; cycles(3, "R1");
    rst = 1'b1; cycles(2, "R1");
    rst = 1'b0; raw_a = 1'b0; cycles(2, "R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    process_seed_init();
  end

  function automatic void process_seed_init();
    int unsigned s;
    s = $urandom(32'd20240611);
  endfunction

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule